// File: doc/BRIEF.md
# MDIO Auto-Poll Change Detector

This block watches one register of an external PHY over the MII management interface. While polling is on, it sends a read frame on MDC/MDIO at a fixed interval and compares each returned 16-bit value with the value it stored from the previous read. When the two differ, it sets a sticky interrupt flag. Software clears the flag by writing 1 to it. The block never writes to the PHY.

A 16-bit control register holds the settings:

- a local enable;
- the PHY address and the register number to read;
- a preamble-suppression bit;
- a default-PHY select bit.

With default-PHY select set, the frame address comes from the `dflt_addr_i` input and the preamble decision comes from `dflt_nopre_i`. The matching local fields are then ignored. Polling runs only while both the local enable and the global enable input are high.

A comparison is made only against a baseline taken for the same effective PHY address and register number. The first read after polling starts, and the first read after the target changes, only loads the baseline.

Top module: `mdio_autopoll`

## Requirements
- R1: After reset the control register reads 0, `irq_o` is 0 and `mdio_oe_o` is 0.
- R2: Control bits 14, 13 and 7 always read 0. Bit 15 is the enable, bits 12-8 the register number, bit 6 preamble suppression, bit 5 default-PHY select and bits 4-0 the PHY address.
- R3: While control bit 15 or `glb_en_i` is 0, no frame is driven and `mdio_oe_o` stays 0.
- R4: A read frame is 32 ones, then `01`, `10`, the 5-bit PHY address and the 5-bit register number, all MSB first. After that, `mdio_oe_o` drops for a two-bit turnaround followed by 16 data bits.
- R5: With bit 5 = 0, the 32-bit preamble is omitted exactly when bit 6 = 1.
- R6: With bit 5 = 1, the frame carries `dflt_addr_i` as the PHY address, and bits 4-0 have no effect.
- R7: With bit 5 = 1, the preamble is omitted exactly when `dflt_nopre_i` = 1, and bit 6 has no effect.
- R8: `mdc_o` has a period of CLK_DIV clocks with a 50% duty cycle. `mdio_o` and `mdio_oe_o` change only on a falling MDC edge. Data is sampled on rising MDC edges, MSB first.
- R9: From the MDC falling edge that ends a frame to the start of the next frame there are exactly IDLE_MDC MDC falling edges.
- R10: The first read after polling is enabled, and the first read whose effective PHY address or register number differs from the baseline's, does not set `irq_o`.
- R11: A read returning a value different from the baseline of the same target sets `irq_o`. The flag stays set until it is cleared.
- R12: A high `irq_clr_i` clears `irq_o`, unless a detection occurs in the same cycle, in which case `irq_o` stays 1.
- R13: Dropping either enable in the middle of a frame aborts it, and `mdio_oe_o` is 0 on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Control register write strobe |
| cfg_wdata_i | input | 16 | Control register write data |
| cfg_rdata_o | output | 16 | Control register contents |
| irq_clr_i | input | 1 | Write-1-to-clear of the interrupt flag |
| irq_o | output | 1 | Sticky change-detected flag |
| glb_en_i | input | 1 | Global auto-poll enable |
| dflt_addr_i | input | 5 | Default PHY address |
| dflt_nopre_i | input | 1 | Default PHY accepts frames without preamble |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe_o | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data in |

## Verification
The hardest case to reach from the ports is a clear that lands in the same clock as a detection. Detection happens only on the MDC falling edge that closes the data phase. To hit that cycle, the bench counts the sixteen rising MDC edges from the start of the data phase. It then waits half an MDC period less one clock and raises `irq_clr_i` for exactly that one clock. The other sequences need little setup: a single-bit sweep of the PHY value covers every data bit position, and aborts are forced a few MDC edges into a preamble.

// File: rtl/mdio_ap_pkg.sv
package mdio_ap_pkg;
  typedef struct packed {
    logic       en;
    logic [1:0] rsv_hi;
    logic [4:0] reg_num;
    logic       rsv_lo;
    logic       nopre;
    logic       dflt;
    logic [4:0] phy;
  } ap_cfg_t;

  localparam logic [15:0] CFG_WMASK = 16'h9F7F;

  typedef struct packed {
    logic [4:0] phy;
    logic [4:0] reg_num;
  } ap_key_t;

  typedef enum logic [2:0] {ST_IDLE, ST_PRE, ST_CMD, ST_TA, ST_DATA} fr_state_e;
endpackage

// File: rtl/mdio_ap_cfg.sv
module mdio_ap_cfg
  import mdio_ap_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        we_i,
  input  logic [15:0] wdata_i,
  input  logic        glb_en_i,
  input  logic [4:0]  dflt_addr_i,
  input  logic        dflt_nopre_i,
  output logic [15:0] rdata_o,
  output ap_key_t     key_o,
  output logic        nopre_o,
  output logic        act_o
);
  ap_cfg_t cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cfg_q <= '0;
    else if (we_i) cfg_q <= ap_cfg_t'(wdata_i & CFG_WMASK);
  end

  assign rdata_o       = cfg_q;
  assign act_o         = cfg_q.en & glb_en_i;
  assign key_o.phy     = cfg_q.dflt ? dflt_addr_i : cfg_q.phy;
  assign key_o.reg_num = cfg_q.reg_num;
  assign nopre_o       = cfg_q.dflt ? dflt_nopre_i : cfg_q.nopre;
endmodule

// File: rtl/mdio_ap_clkdiv.sv
module mdio_ap_clkdiv #(
  parameter int CLK_DIV = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic mdc_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int HALF = CLK_DIV / 2;
  localparam int CW   = $clog2(CLK_DIV);

  logic [CW-1:0] cnt_q;
  logic          mdc_q;

  assign rise_o = (cnt_q == CW'(HALF - 1));
  assign fall_o = (cnt_q == CW'(CLK_DIV - 1));
  assign mdc_o  = mdc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else begin
      cnt_q <= fall_o ? '0 : cnt_q + CW'(1);
      if (rise_o)      mdc_q <= 1'b1;
      else if (fall_o) mdc_q <= 1'b0;
    end
  end
endmodule

// File: rtl/mdio_ap_frame.sv
module mdio_ap_frame
  import mdio_ap_pkg::*;
#(
  parameter int PRE_LEN  = 32,
  parameter int IDLE_MDC = 1024
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        act_i,
  input  ap_key_t     key_i,
  input  logic        nopre_i,
  input  logic        rise_i,
  input  logic        fall_i,
  input  logic        mdio_i,
  output logic        mdio_o,
  output logic        mdio_oe_o,
  output logic        rd_valid_o,
  output logic [15:0] rd_data_o,
  output ap_key_t     rd_key_o
);
  localparam int BMAX = (PRE_LEN > 16) ? PRE_LEN : 16;
  localparam int BCW  = $clog2(BMAX);
  localparam int ICW  = $clog2(IDLE_MDC + 1);

  fr_state_e      st_q;
  logic [BCW-1:0] bit_q;
  logic [ICW-1:0] idle_q;
  logic [13:0]    cmd_q;
  logic [15:0]    rd_q;
  ap_key_t        key_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      bit_q  <= '0;
      idle_q <= '0;
      cmd_q  <= '0;
      rd_q   <= '0;
      key_q  <= '0;
    end else if (!act_i) begin
      st_q   <= ST_IDLE;
      bit_q  <= '0;
      idle_q <= '0;
    end else begin
      if (rise_i && st_q == ST_DATA) rd_q <= {rd_q[14:0], mdio_i};
      if (fall_i) begin
        unique case (st_q)
          ST_IDLE: begin
            if (idle_q == ICW'(IDLE_MDC - 1)) begin
              idle_q <= '0;
              bit_q  <= '0;
              key_q  <= key_i;
              cmd_q  <= {4'b0110, key_i};
              st_q   <= nopre_i ? ST_CMD : ST_PRE;
            end else begin
              idle_q <= idle_q + ICW'(1);
            end
          end
          ST_PRE: begin
            if (bit_q == BCW'(PRE_LEN - 1)) begin
              bit_q <= '0;
              st_q  <= ST_CMD;
            end else bit_q <= bit_q + BCW'(1);
          end
          ST_CMD: begin
            cmd_q <= cmd_q << 1;
            if (bit_q == BCW'(13)) begin
              bit_q <= '0;
              st_q  <= ST_TA;
            end else bit_q <= bit_q + BCW'(1);
          end
          ST_TA: begin
            if (bit_q == BCW'(1)) begin
              bit_q <= '0;
              st_q  <= ST_DATA;
            end else bit_q <= bit_q + BCW'(1);
          end
          ST_DATA: begin
            if (bit_q == BCW'(15)) begin
              bit_q <= '0;
              st_q  <= ST_IDLE;
            end else bit_q <= bit_q + BCW'(1);
          end
          default: st_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign mdio_oe_o  = (st_q == ST_PRE) || (st_q == ST_CMD);
  assign mdio_o     = (st_q == ST_PRE) || ((st_q == ST_CMD) && cmd_q[13]);
  assign rd_valid_o = act_i && fall_i && (st_q == ST_DATA) && (bit_q == BCW'(15));
  assign rd_data_o  = rd_q;
  assign rd_key_o   = key_q;
endmodule

// File: rtl/mdio_ap_cmp.sv
module mdio_ap_cmp
  import mdio_ap_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        act_i,
  input  logic        rd_valid_i,
  input  logic [15:0] rd_data_i,
  input  ap_key_t     rd_key_i,
  input  logic        clr_i,
  output logic        irq_o
);
  logic        base_vld_q;
  ap_key_t     base_key_q;
  logic [15:0] base_q;
  logic        irq_q;
  logic        det;

  // compare only against a baseline of the same target
  assign det = rd_valid_i && base_vld_q && (rd_key_i == base_key_q) && (rd_data_i != base_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_vld_q <= 1'b0;
      base_key_q <= '0;
      base_q     <= '0;
      irq_q      <= 1'b0;
    end else begin
      if (!act_i) begin
        base_vld_q <= 1'b0;
      end else if (rd_valid_i) begin
        base_vld_q <= 1'b1;
        base_key_q <= rd_key_i;
        base_q     <= rd_data_i;
      end
      irq_q <= (irq_q & ~clr_i) | det;
    end
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/mdio_autopoll.sv
module mdio_autopoll
  import mdio_ap_pkg::*;
#(
  parameter int CLK_DIV  = 8,
  parameter int IDLE_MDC = 1024,
  parameter int PRE_LEN  = 32
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        cfg_we_i,
  input  logic [15:0] cfg_wdata_i,
  output logic [15:0] cfg_rdata_o,
  input  logic        irq_clr_i,
  output logic        irq_o,
  input  logic        glb_en_i,
  input  logic [4:0]  dflt_addr_i,
  input  logic        dflt_nopre_i,
  output logic        mdc_o,
  output logic        mdio_o,
  output logic        mdio_oe_o,
  input  logic        mdio_i
);
  ap_key_t     key, rd_key;
  logic        nopre, act, rise, fall, rd_valid;
  logic [15:0] rd_data;

  mdio_ap_cfg u_cfg (
    .clk_i, .rst_ni,
    .we_i(cfg_we_i), .wdata_i(cfg_wdata_i),
    .glb_en_i, .dflt_addr_i, .dflt_nopre_i,
    .rdata_o(cfg_rdata_o), .key_o(key), .nopre_o(nopre), .act_o(act)
  );

  mdio_ap_clkdiv #(.CLK_DIV(CLK_DIV)) u_div (
    .clk_i, .rst_ni, .mdc_o, .rise_o(rise), .fall_o(fall)
  );

  mdio_ap_frame #(.PRE_LEN(PRE_LEN), .IDLE_MDC(IDLE_MDC)) u_frame (
    .clk_i, .rst_ni, .act_i(act), .key_i(key), .nopre_i(nopre),
    .rise_i(rise), .fall_i(fall), .mdio_i,
    .mdio_o, .mdio_oe_o,
    .rd_valid_o(rd_valid), .rd_data_o(rd_data), .rd_key_o(rd_key)
  );

  mdio_ap_cmp u_cmp (
    .clk_i, .rst_ni, .act_i(act),
    .rd_valid_i(rd_valid), .rd_data_i(rd_data), .rd_key_i(rd_key),
    .clr_i(irq_clr_i), .irq_o
  );
endmodule

// File: rtl/mdio_autopoll_chk.sv
module mdio_autopoll_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [15:0] cfg_rdata_o,
  input logic        glb_en_i,
  input logic        irq_clr_i,
  input logic        irq_o,
  input logic        mdc_o,
  input logic        mdio_o,
  input logic        mdio_oe_o
);
  logic act;
  assign act = cfg_rdata_o[15] & glb_en_i;

  p_rsvd_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_rdata_o & 16'h6080) == 16'h0);

  p_quiet_off_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !act |=> !mdio_oe_o);

  p_start_on_fall_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mdio_oe_o) |-> $fell(mdc_o));

  p_drive_on_fall_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($changed(mdio_o) || $changed(mdio_oe_o)) && $past(act) |-> $fell(mdc_o));

  p_irq_sticky_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o && !irq_clr_i |=> irq_o);

  p_irq_at_end_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $fell(mdc_o));
endmodule

bind mdio_autopoll mdio_autopoll_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cfg_rdata_o(cfg_rdata_o),
  .glb_en_i(glb_en_i), .irq_clr_i(irq_clr_i), .irq_o(irq_o),
  .mdc_o(mdc_o), .mdio_o(mdio_o), .mdio_oe_o(mdio_oe_o)
);

// File: tb/mdio_autopoll_tb.sv
`timescale 1ns/1ps
module mdio_autopoll_tb;
  localparam int CLK_DIV  = 4;
  localparam int IDLE_MDC = 4;
  localparam int PRE_LEN  = 32;
  localparam int HALF     = CLK_DIV / 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0, irq_clr = 1'b0, glb_en = 1'b0, dflt_nopre = 1'b0, mdio_in = 1'b0;
  logic [15:0] cfg_wdata = '0;
  logic [4:0]  dflt_addr = '0;
  logic [15:0] cfg_rdata;
  logic irq, mdc, mdio_out, mdio_oe;

  int n_chk = 0, n_err = 0;
  bit fin = 0;
  int done_cnt = 0, data_cnt = 0, last_n = 0;
  logic [13:0] last_sh = '0;
  logic [15:0] phy_val = 16'h0;

  always #4 clk = ~clk;

  mdio_autopoll #(.CLK_DIV(CLK_DIV), .IDLE_MDC(IDLE_MDC), .PRE_LEN(PRE_LEN)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_wdata_i(cfg_wdata),
    .cfg_rdata_o(cfg_rdata), .irq_clr_i(irq_clr), .irq_o(irq), .glb_en_i(glb_en),
    .dflt_addr_i(dflt_addr), .dflt_nopre_i(dflt_nopre), .mdc_o(mdc),
    .mdio_o(mdio_out), .mdio_oe_o(mdio_oe), .mdio_i(mdio_in)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act_v, input logic [31:0] exp_v);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act_v, exp_v);
    end
  endtask

  task automatic summary();
    if (!fin) begin
      fin = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
      $finish;
    end
  endtask

  task automatic wr(input logic [15:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_wdata = d;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic clr_pulse();
    @(negedge clk); irq_clr = 1'b1;
    @(negedge clk); irq_clr = 1'b0;
  endtask

  task automatic wait_done();
    int t;
    t = done_cnt;
    wait (done_cnt != t);
  endtask

  function automatic logic [15:0] cfgw(input bit en, input logic [4:0] rg, input bit sup,
                                       input bit df, input logic [4:0] ad);
    return {en, 2'b00, rg, 1'b0, sup, df, ad};
  endfunction

  // PHY model: decodes command, returns phy_val
  initial begin
    forever begin
      int n;
      logic [13:0] sh;
      logic [15:0] v;
      @(posedge mdio_oe);
      n = 0; sh = '0;
      forever begin
        @(posedge mdc);
        if (!mdio_oe) break;
        sh = {sh[12:0], mdio_out};
        n++;
      end
      if (n >= 14) begin
        last_n = n; last_sh = sh;
        @(negedge mdc);
        @(negedge mdc);
        v = phy_val;
        mdio_in = v[15];
        data_cnt++;
        for (int i = 14; i >= 0; i--) begin
          @(negedge mdc);
          mdio_in = v[i];
        end
        @(negedge mdc);
        @(negedge clk);
        done_cnt++;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [15:0] w;
    time t0;
    int n;
    // R1 reset state
    repeat (5) @(negedge clk);
    chk(cfg_rdata == 16'h0, "R1", "cfg in reset", cfg_rdata, 0);
    chk(irq == 1'b0, "R1", "irq in reset", irq, 0);
    chk(mdio_oe == 1'b0, "R1", "oe in reset", mdio_oe, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(cfg_rdata == 16'h0, "R1", "cfg after reset", cfg_rdata, 0);

    // R2 reserved bits
    wr(16'hFFFF);
    chk(cfg_rdata == 16'h9F7F, "R2", "all-ones readback", cfg_rdata, 16'h9F7F);
    wr(16'h6080);
    chk(cfg_rdata == 16'h0, "R2", "reserved-only write", cfg_rdata, 0);

    // R3 no polling with one enable low
    glb_en = 1'b1;
    wr(cfgw(0, 5'd2, 0, 0, 5'd3));
    n = 0;
    repeat (400) begin @(negedge clk); if (mdio_oe) n++; end
    chk(n == 0, "R3", "oe with local enable off", n, 0);
    glb_en = 1'b0;
    wr(cfgw(1, 5'd2, 0, 0, 5'd3));
    n = 0;
    repeat (400) begin @(negedge clk); if (mdio_oe) n++; end
    chk(n == 0, "R3", "oe with global enable off", n, 0);
    wr(16'h0);
    glb_en = 1'b1;

    // R8 MDC period and duty
    @(posedge mdc); t0 = $time;
    @(negedge mdc);
    chk(($time - t0) == HALF * 8, "R8", "mdc high time", 32'($time - t0), HALF * 8);
    @(posedge mdc);
    chk(($time - t0) == CLK_DIV * 8, "R8", "mdc period", 32'($time - t0), CLK_DIV * 8);

    // R4..R7 frame format sweep
    for (int k = 0; k < 4; k++) begin
      for (int m = 0; m < 8; m++) begin
        logic [4:0] ad, rg, ep;
        bit sup, df, dnp;
        int ep_pre;
        ad = 5'((k * 13 + 1) & 31);
        rg = 5'((k * 7 + 30) & 31);
        sup = m[0]; df = m[1]; dnp = m[2];
        wr(16'h0);
        dflt_addr = ~ad;
        dflt_nopre = dnp;
        wr(cfgw(1, rg, sup, df, ad));
        wait_done();
        ep = df ? ~ad : ad;
        ep_pre = df ? (dnp ? 0 : PRE_LEN) : (sup ? 0 : PRE_LEN);
        chk(last_n == ep_pre + 14, df ? "R7" : "R5", "bits before turnaround", last_n, ep_pre + 14);
        chk(last_sh[13:10] == 4'b0110, "R4", "start and opcode", last_sh[13:10], 4'b0110);
        chk(last_sh[9:5] == ep, df ? "R6" : "R4", "phy address", last_sh[9:5], ep);
        chk(last_sh[4:0] == rg, "R4", "register number", last_sh[4:0], rg);
      end
    end

    // R9 idle gap
    n = 0;
    while (!mdio_oe) begin @(negedge mdc); #1; n++; end
    chk(n == IDLE_MDC, "R9", "idle mdc falls", n, IDLE_MDC);

    // R10..R12 change detection
    wr(16'h0);
    dflt_nopre = 1'b0;
    clr_pulse();
    phy_val = 16'hA5A5;
    w = cfgw(1, 5'd2, 1, 0, 5'd3);
    wr(w);
    wait_done();
    chk(irq == 1'b0, "R10", "first read after enable", irq, 0);
    wait_done();
    chk(irq == 1'b0, "R11", "unchanged value", irq, 0);
    for (int b = 0; b < 16; b++) begin
      phy_val = phy_val ^ (16'h1 << b);
      wait_done();
      chk(irq == 1'b1, "R11", $sformatf("bit %0d change", b), irq, 1);
      wait_done();
      chk(irq == 1'b1, "R11", "sticky across unchanged read", irq, 1);
      clr_pulse();
      chk(irq == 1'b0, "R12", "clear", irq, 0);
    end
    phy_val = 16'h0000;
    wait_done();
    phy_val = 16'hFFFF;
    wait_done();
    chk(irq == 1'b1, "R11", "all bits flip", irq, 1);
    clr_pulse();

    // R10 target change reloads baseline
    w = cfgw(1, 5'd9, 1, 0, 5'd3);
    wr(w);
    phy_val = phy_val ^ 16'hFFFF;
    wait_done();
    chk(irq == 1'b0, "R10", "first read of new register", irq, 0);
    phy_val = phy_val ^ 16'h0001;
    wait_done();
    chk(irq == 1'b1, "R11", "change on new register", irq, 1);
    clr_pulse();

    // R12 clear in the detection cycle
    begin
      int t;
      phy_val = phy_val ^ 16'h8000;
      t = data_cnt;
      wait (data_cnt != t);
      repeat (16) @(posedge mdc);
      repeat (HALF - 1) @(posedge clk);
      @(negedge clk); irq_clr = 1'b1;
      @(posedge clk);
      @(negedge clk); irq_clr = 1'b0;
      chk(irq == 1'b1, "R12", "clear coincident with detection", irq, 1);
      clr_pulse();
      chk(irq == 1'b0, "R12", "clear afterwards", irq, 0);
    end

    // R13 aborts, then R10 after re-enable
    w = cfgw(1, 5'd9, 0, 0, 5'd3);
    wr(w);
    @(posedge mdio_oe);
    repeat (3) @(posedge mdc);
    wr(w & 16'h7FFF);
    @(negedge clk);
    chk(mdio_oe == 1'b0, "R13", "abort by local enable", mdio_oe, 0);
    n = 0;
    repeat (100) begin @(negedge clk); if (mdio_oe) n++; end
    chk(n == 0, "R3", "quiet after abort", n, 0);
    wr(w);
    @(posedge mdio_oe);
    repeat (3) @(posedge mdc);
    @(negedge clk); glb_en = 1'b0;
    @(negedge clk);
    chk(mdio_oe == 1'b0, "R13", "abort by global enable", mdio_oe, 0);
    repeat (20) @(negedge clk);
    glb_en = 1'b1;
    phy_val = phy_val ^ 16'h00FF;
    wait_done();
    chk(irq == 1'b0, "R10", "first read after re-enable", irq, 0);

    summary();
  end
endmodule